// File: doc/BRIEF.md
# Multi-Size Translation Cache

This block is a small fully associative cache of address translations that sits in front of a page table walker. Each entry maps one virtual page to one physical page and records its own page size: 4 KB, 64 KB or 1 MB. A lookup compares the virtual address against every entry at once. It reports a single hit together with the translated physical address, a miss, or a multi-hit fault. The multi-hit fault is split into a read flavour and a write flavour.

The walker installs translations through a fill port. A fill goes to a free entry when one exists. Otherwise it replaces the least recently used entry. Software-style maintenance arrives as a one-cycle flush-all strobe and as an invalidate command word. The command word carries a 4 KB-aligned virtual address and a request flag. Lookup results are combinational on the current contents. Fills, invalidations and recency updates take effect at the next clock edge.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so any served lookup reports `lk_miss`.
- R2: `fill_size` encodes 2'b00 = 4 KB (compares virtual bits [31:12]), 2'b01 = 64 KB (bits [31:16]) and 2'b10 = 1 MB (bits [31:20]). On a hit, `lk_paddr` is the stored physical address above that boundary joined with the lookup address below it.
- R3: A served lookup (`lk_valid`=1, `fill_valid`=0) with exactly one covering valid entry raises `lk_hit` with the translated address in the same cycle. With no covering entry it raises `lk_miss`.
- R4: A served lookup with two or more covering valid entries raises `lk_rd_multi` when `lk_write`=0 and `lk_wr_multi` when `lk_write`=1, with neither `lk_hit` nor `lk_miss`. At most one of the four outcome outputs is high in any cycle.
- R5: A fill is written into an invalid entry whenever one exists, so no valid translation is displaced while space remains.
- R6: When all entries are valid, a fill replaces the least recently used one. Recency is refreshed by every fill and by every single-hit lookup. A multi-hit lookup does not refresh recency.
- R7: `flush_all` makes every entry invalid from the next cycle on, and it overrides a fill in the same cycle.
- R8: `inv_cmd` bit 0 = 1 requests invalidation of the page address in bits [31:12]; bits [11:1] are ignored. Every valid entry whose span contains that address is removed, including 64 KB and 1 MB entries.
- R9: An `inv_cmd` word with bit 0 = 0 changes no entry.
- R10: When `fill_valid` and `lk_valid` are high in the same cycle, the fill is performed. The lookup raises none of the four outcomes and does not refresh recency.
- R11: A fill with size code 2'b11 is discarded and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a write access (selects the multi-hit flavour) |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Exactly one entry matched |
| lk_miss | output | 1 | No entry matched |
| lk_rd_multi | output | 1 | Several entries matched a read lookup |
| lk_wr_multi | output | 1 | Several entries matched a write lookup |
| lk_paddr | output | 32 | Translated physical address, valid with lk_hit |
| fill_valid | input | 1 | Install a translation |
| fill_size | input | 2 | Page size code of the fill |
| fill_vaddr | input | 32 | Virtual page address of the fill |
| fill_paddr | input | 32 | Physical page address of the fill |
| flush_all | input | 1 | Invalidate every entry |
| inv_cmd | input | 32 | Single-address invalidate word: page address in [31:12], request in bit 0 |

## Verification
A lookup and a fill can arrive in the same cycle, and so can a lookup and an invalidate. The bench provokes the first with directed collisions and with a random mix in which both strobes are drawn independently. It judges each collision against a behavioural recency-ordered list. The list expects no lookup outcome, and it expects later lookups to show the fill installed and the recency order unchanged by the blocked lookup. For lookup with invalidate, the lookup is judged on the contents before the edge, and the next cycle must show every covering entry gone.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int PN_W = 20;

  typedef enum logic [1:0] {
    PG_4K  = 2'b00,
    PG_64K = 2'b01,
    PG_1M  = 2'b10,
    PG_BAD = 2'b11
  } pg_size_t;

  typedef struct packed {
    logic            vld;
    pg_size_t        sz;
    logic [PN_W-1:0] vtag;
    logic [PN_W-1:0] ptag;
  } xlat_ent_t;

  // True when the entry's page span contains the given 4 KB page number.
  function automatic logic span_covers(xlat_ent_t e, logic [PN_W-1:0] pn);
    case (e.sz)
      PG_1M:   return e.vtag[PN_W-1:8] == pn[PN_W-1:8];
      PG_64K:  return e.vtag[PN_W-1:4] == pn[PN_W-1:4];
      PG_4K:   return e.vtag == pn;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  xlat_ent_t [DEPTH-1:0] ents,
  input  logic [PN_W-1:0]       pn,
  output logic [DEPTH-1:0]      cover_vec
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign cover_vec[g] = ents[g].vld && span_covers(ents[g], pn);
  end

endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] oldest_idx
);

  // Rank per entry: 0 = most recent, DEPTH-1 = least recent.
  logic [DEPTH-1:0][IW-1:0] ages_q, ages_d;
  logic [DEPTH-1:0]         oldest_vec;

  always_comb begin
    ages_d = ages_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (IW'(i) == touch_idx) begin
        ages_d[i] = '0;
      end else if (ages_q[i] < ages_q[touch_idx]) begin
        ages_d[i] = ages_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ages_q[i] <= IW'(i);
    end else if (touch_en) begin
      ages_q <= ages_d;
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      oldest_vec[i] = (ages_q[i] == IW'(DEPTH - 1));
      if (oldest_vec[i]) oldest_idx = IW'(i);
    end
  end

  // R6
  single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest_vec));

  // R6
  mru_after_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (ages_q[$past(touch_idx)] == '0));

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] vld,
  input  logic [IW-1:0]    lru_idx,
  output logic [IW-1:0]    victim_idx
);

  logic          any_free;
  logic [IW-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IW'(i);
    end
  end

  assign any_free   = ~&vld;
  assign victim_idx = any_free ? free_idx : lru_idx;

  // R5
  free_slot_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_free |-> !vld[victim_idx]);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  input  logic        lk_write,
  input  logic [31:0] lk_vaddr,
  output logic        lk_hit,
  output logic        lk_miss,
  output logic        lk_rd_multi,
  output logic        lk_wr_multi,
  output logic [31:0] lk_paddr,
  input  logic        fill_valid,
  input  logic [1:0]  fill_size,
  input  logic [31:0] fill_vaddr,
  input  logic [31:0] fill_paddr,
  input  logic        flush_all,
  input  logic [31:0] inv_cmd
);

  xlat_ent_t [DEPTH-1:0] ents_q, ents_d;
  logic [DEPTH-1:0] vld_vec, vld_post, lk_vec, inv_vec;
  logic             ents_en;
  logic             lk_served, lk_any, lk_single;
  logic             inv_req, fill_ok;
  logic [IW-1:0]    hit_idx, victim_idx, lru_idx, touch_idx;
  logic             touch_en;
  xlat_ent_t        hit_ent;
  logic             unused_bits;

  assign unused_bits = ^{fill_vaddr[11:0], fill_paddr[11:0], inv_cmd[11:1]};

  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    assign vld_vec[g]  = ents_q[g].vld;
    assign vld_post[g] = ents_q[g].vld & ~(inv_req & inv_vec[g]);
  end

  xlat_match #(.DEPTH(DEPTH)) u_lk_match (
    .ents(ents_q), .pn(lk_vaddr[31:12]), .cover_vec(lk_vec)
  );

  xlat_match #(.DEPTH(DEPTH)) u_inv_match (
    .ents(ents_q), .pn(inv_cmd[31:12]), .cover_vec(inv_vec)
  );

  xlat_lru #(.DEPTH(DEPTH)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en),
    .touch_idx(touch_idx), .oldest_idx(lru_idx)
  );

  xlat_victim #(.DEPTH(DEPTH)) u_victim (
    .clk(clk), .rst_n(rst_n), .vld(vld_post),
    .lru_idx(lru_idx), .victim_idx(victim_idx)
  );

  // Lookup side: combinational on current contents, blocked by a fill.
  assign lk_served = lk_valid && !fill_valid;
  assign lk_any    = |lk_vec;
  assign lk_single = $onehot(lk_vec);

  always_comb begin
    hit_idx = '0;
    hit_ent = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lk_vec[i]) begin
        hit_idx = IW'(i);
        hit_ent = ents_q[i];
      end
    end
  end

  always_comb begin
    lk_hit      = lk_served && lk_single;
    lk_miss     = lk_served && !lk_any;
    lk_rd_multi = lk_served && lk_any && !lk_single && !lk_write;
    lk_wr_multi = lk_served && lk_any && !lk_single && lk_write;
    lk_paddr    = '0;
    if (lk_hit) begin
      case (hit_ent.sz)
        PG_1M:   lk_paddr = {hit_ent.ptag[PN_W-1:8], lk_vaddr[19:0]};
        PG_64K:  lk_paddr = {hit_ent.ptag[PN_W-1:4], lk_vaddr[15:0]};
        default: lk_paddr = {hit_ent.ptag, lk_vaddr[11:0]};
      endcase
    end
  end

  // Update side.
  assign inv_req   = inv_cmd[0];
  assign fill_ok   = fill_valid && (pg_size_t'(fill_size) != PG_BAD) && !flush_all;
  assign touch_en  = fill_ok || lk_hit;
  assign touch_idx = fill_ok ? victim_idx : hit_idx;
  assign ents_en   = flush_all || inv_req || fill_ok;

  always_comb begin
    ents_d = ents_q;
    for (int i = 0; i < DEPTH; i++) ents_d[i].vld = vld_post[i];
    if (fill_ok) begin
      ents_d[victim_idx].vld  = 1'b1;
      ents_d[victim_idx].sz   = pg_size_t'(fill_size);
      ents_d[victim_idx].vtag = fill_vaddr[31:12];
      ents_d[victim_idx].ptag = fill_paddr[31:12];
    end
    if (flush_all) begin
      for (int i = 0; i < DEPTH; i++) ents_d[i].vld = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ents_q <= '0;
    end else if (ents_en) begin
      ents_q <= ents_d;
    end
  end

  // R4
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_rd_multi, lk_wr_multi}));

  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (vld_vec == '0));

  // R10
  fill_blocks_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !(lk_hit || lk_miss || lk_rd_multi || lk_wr_multi));

  // R11
  bad_size_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_size == 2'b11 && !inv_cmd[0] && !flush_all)
      |=> (ents_q == $past(ents_q)));

  // R8
  inv_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && !fill_valid) |=> ((vld_vec & $past(inv_vec)) == '0));

endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;

  localparam int DEPTH = 8;

  logic        clk, rst_n;
  logic        lk_valid, lk_write;
  logic [31:0] lk_vaddr, lk_paddr;
  logic        lk_hit, lk_miss, lk_rd_multi, lk_wr_multi;
  logic        fill_valid;
  logic [1:0]  fill_size;
  logic [31:0] fill_vaddr, fill_paddr, inv_cmd;
  logic        flush_all;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string phase = "R1";

  // Reference model: index 0 = most recently used.
  logic [31:0] m_va[$];
  logic [31:0] m_pa[$];
  logic [1:0]  m_sz[$];

  xlat_cache #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_rd_multi(lk_rd_multi), .lk_wr_multi(lk_wr_multi), .lk_paddr(lk_paddr),
    .fill_valid(fill_valid), .fill_size(fill_size), .fill_vaddr(fill_vaddr),
    .fill_paddr(fill_paddr), .flush_all(flush_all), .inv_cmd(inv_cmd)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit m_cov(logic [31:0] va, logic [1:0] sz, logic [31:0] a);
    case (sz)
      2'd2:    return va[31:20] == a[31:20];
      2'd1:    return va[31:16] == a[31:16];
      2'd0:    return va[31:12] == a[31:12];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_xl(logic [31:0] pa, logic [1:0] sz, logic [31:0] a);
    case (sz)
      2'd2:    return {pa[31:20], a[19:0]};
      2'd1:    return {pa[31:16], a[15:0]};
      default: return {pa[31:12], a[11:0]};
    endcase
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic step(input bit lv, input bit lw, input logic [31:0] la,
                      input bit fv, input logic [31:0] fva, input logic [31:0] fpa,
                      input logic [1:0] fsz, input logic [31:0] inv, input bit fa);
    logic [3:0]  exp4;
    logic [31:0] exp_pa;
    int          n, hix;
    string       t;
    @(negedge clk);
    lk_valid = lv; lk_write = lw; lk_vaddr = la;
    fill_valid = fv; fill_vaddr = fva; fill_paddr = fpa; fill_size = fsz;
    inv_cmd = inv; flush_all = fa;
    #2;
    exp4 = 4'b0000; exp_pa = '0; n = 0; hix = -1;
    if (lv && !fv) begin
      foreach (m_va[i]) if (m_cov(m_va[i], m_sz[i], la)) begin n++; hix = i; end
      if (n == 0) exp4 = 4'b0100;
      else if (n == 1) begin exp4 = 4'b1000; exp_pa = m_xl(m_pa[hix], m_sz[hix], la); end
      else exp4 = lw ? 4'b0001 : 4'b0010;
    end
    t = phase;
    if (lv && fv) t = "R10";
    else if (exp4[1] || exp4[0]) t = "R4";
    checks++;
    if ({lk_hit, lk_miss, lk_rd_multi, lk_wr_multi} !== exp4 ||
        (exp4[3] && lk_paddr !== exp_pa)) begin
      errors++;
      $display("FAIL %s: la=%h outcome=%b paddr=%h expected outcome=%b paddr=%h",
               t, la, {lk_hit, lk_miss, lk_rd_multi, lk_wr_multi}, lk_paddr, exp4, exp_pa);
    end
    // Model update, as seen after the coming edge.
    if (exp4[3]) begin
      logic [31:0] a, b; logic [1:0] s;
      a = m_va[hix]; b = m_pa[hix]; s = m_sz[hix];
      m_va.delete(hix); m_pa.delete(hix); m_sz.delete(hix);
      m_va.push_front(a); m_pa.push_front(b); m_sz.push_front(s);
    end
    if (fa) begin
      m_va.delete(); m_pa.delete(); m_sz.delete();
    end else begin
      if (inv[0]) begin
        for (int i = m_va.size() - 1; i >= 0; i--) begin
          if (m_cov(m_va[i], m_sz[i], {inv[31:12], 12'h000})) begin
            m_va.delete(i); m_pa.delete(i); m_sz.delete(i);
          end
        end
      end
      if (fv && fsz != 2'b11) begin
        if (m_va.size() == DEPTH) begin
          void'(m_va.pop_back()); void'(m_pa.pop_back()); void'(m_sz.pop_back());
        end
        m_va.push_front(fva); m_pa.push_front(fpa); m_sz.push_front(fsz);
      end
    end
  endtask

  task automatic look(input logic [31:0] a, input bit w);
    step(1, w, a, 0, '0, '0, 2'd0, '0, 0);
  endtask
  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
    step(0, 0, '0, 1, va, pa, sz, '0, 0);
  endtask
  task automatic inval(input logic [31:0] w);
    step(0, 0, '0, 0, '0, '0, 2'd0, w, 0);
  endtask
  task automatic flush();
    step(0, 0, '0, 0, '0, '0, 2'd0, '0, 1);
  endtask

  function automatic logic [31:0] rnd_addr();
    return (32'($urandom_range(0, 3)) << 20) | (32'($urandom_range(0, 3)) << 16) |
           (32'($urandom_range(0, 3)) << 12) | 32'($urandom_range(0, 4095));
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    lk_valid = 0; lk_write = 0; lk_vaddr = '0; fill_valid = 0; fill_size = '0;
    fill_vaddr = '0; fill_paddr = '0; inv_cmd = '0; flush_all = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    phase = "R1";
    look(32'h0000_0000, 0); look(32'h1234_5678, 1); look(32'hFFFF_F000, 0);

    // R2/R3: each size, offsets and boundaries
    phase = "R2";
    fill(32'h0010_0000, 32'h8000_0000, 2'd2);
    look(32'h001A_BCDE, 0); look(32'h0020_0000, 0);
    fill(32'h0201_0000, 32'h9003_0000, 2'd1);
    look(32'h0201_1234, 0); look(32'h0202_0000, 0); look(32'h0200_FFFF, 0);
    fill(32'h0500_7000, 32'hA123_4000, 2'd0);
    look(32'h0500_7ABC, 1); look(32'h0500_8000, 0);
    phase = "R3";
    look(32'h0010_0004, 0); look(32'h7000_0000, 0);

    // R4: overlapping entries
    phase = "R4";
    fill(32'h0010_5000, 32'hC000_5000, 2'd0);
    look(32'h0010_5010, 0); look(32'h0010_5010, 1);
    look(32'h0010_6000, 0);

    // R9: request bit clear leaves entries intact
    phase = "R9";
    inval(32'h0010_5FFE);
    look(32'h0010_5010, 1);

    // R8: 4 KB address inside 1 MB and 4 KB entries removes both
    phase = "R8";
    inval(32'h0010_5001);
    look(32'h0010_5010, 0); look(32'h001A_BCDE, 0);
    inval(32'h0201_8FFF);
    look(32'h0201_1234, 0); look(32'h0500_7ABC, 0);

    // R7: flush all
    phase = "R7";
    flush();
    look(32'h0500_7ABC, 0);

    // R5: fill every free slot, nothing displaced
    phase = "R5";
    for (int i = 0; i < DEPTH; i++) fill(32'h0400_0000 + (i << 12), 32'hA000_0000 + (i << 12), 2'd0);
    for (int i = 0; i < DEPTH; i++) look(32'h0400_0000 + (i << 12) + 12'h0F0, 0);

    // R6: eviction order follows recency
    phase = "R6";
    look(32'h0400_1000, 0); look(32'h0400_0000, 0);
    fill(32'h0600_0000, 32'hB000_0000, 2'd0);
    look(32'h0400_2000, 0); look(32'h0400_1000, 0); look(32'h0400_0000, 0);
    fill(32'h0601_0000, 32'hB001_0000, 2'd1);
    look(32'h0400_3000, 0); look(32'h0601_FFFF, 0);

    // R10: fill and lookup collide
    phase = "R10";
    step(1, 0, 32'h0400_4000, 1, 32'h0700_0000, 32'hD000_0000, 2'd2, '0, 0);
    look(32'h070F_0000, 0); look(32'h0400_4000, 0);

    // R11: illegal size discarded
    phase = "R11";
    fill(32'h0800_0000, 32'hE000_0000, 2'b11);
    look(32'h0800_0000, 0); look(32'h070F_0000, 0);

    // Random mix
    phase = "R6";
    for (int k = 0; k < 5000; k++) begin
      bit lv, fv, fa;
      logic [31:0] iw;
      lv = ($urandom_range(0, 9) < 6);
      fv = ($urandom_range(0, 9) < 3);
      fa = ($urandom_range(0, 199) == 0);
      iw = ($urandom_range(0, 9) == 0) ?
           {rnd_addr() & 32'hFFFF_F000} | 32'($urandom_range(0, 4095)) : '0;
      step(lv, 1'($urandom_range(0, 1)), rnd_addr(), fv, rnd_addr(), rnd_addr(),
           ($urandom_range(0, 15) == 0) ? 2'b11 : 2'($urandom_range(0, 2)), iw, fa);
    end

    step(0, 0, '0, 0, '0, '0, 2'd0, '0, 0);
    summary();
  end

endmodule